// File: doc/BRIEF.md
# Translation Root Configuration Checker

This block is the first stage of a hardware page-table walker. For each request it takes a 64-bit virtual address, the two translation base registers (one for the lower half of the address space and one for the upper half), the per-half translation settings and a flag that marks an instruction fetch. From these it works out the parameters the walker needs before it reads any memory: which half of the address space is in use, the page size, the number of table levels, the starting level, the span covered by one entry of the root table, the number of root index bits, and the aligned physical address of the root table. It also returns the address with its out-of-range upper bits cleared.

It also checks the configuration and the address. A reserved page-size code or a level count outside the supported range gives an invalid-configuration fault. An address width outside the supported range, or an address whose upper bits are not the canonical pattern for its half, gives an address-size fault. The canonical check can skip the top byte of the address. For instruction fetches this needs a second enable bit. Memory reads and permission checks are done in later walker stages.

The block has one register stage. It accepts a request in any cycle and presents the result, with a valid strobe, one cycle later.

Top module: `rtcc_root_check`

## Requirements
- R1: Address bit 54 picks the half. When it is 1, the upper-half base register and upper-half settings are used and `out_use_hi` is 1. When it is 0, the lower-half ones are used and `out_use_hi` is 0. `out_use_hi` is reported even when there is a fault.
- R2: The page-size code maps as follows: 0 gives a shift of 12 (4 KB), 1 gives 14 (16 KB) and 2 gives 16 (64 KB). Code 3 is reserved and gives fault code 2 (invalid configuration).
- R3: A configured address width below 25 or above 48 gives fault code 1 (address size). A reserved page-size code takes priority and gives code 2. Widths of exactly 25 and 48 are accepted.
- R4: The level count is (width − 1) / shift, using integer division. `out_start_level` is the level count minus one. A level count of zero or above four gives fault code 2.
- R5: `out_span` = shift + (shift − 3) × (levels − 1), and `out_root_bits` = width − `out_span`.
- R6: `out_root` is the selected base register with bits 63:48 and bit 0 cleared, then with its low (`out_root_bits` + 3) bits cleared.
- R7: For the lower half, every address bit at or above the width must be 0. When top-byte skipping is in effect, bits 63:56 are not checked. A violation gives fault code 1.
- R8: For the upper half, every address bit at or above the width must be 1. When top-byte skipping is in effect, bits 63:56 are treated as ones. A violation gives fault code 1.
- R9: Top-byte skipping applies only when the half's skip bit is set. For a fetch request (`in_exec` = 1) it also needs that half's fetch-skip bit to be set.
- R10: `out_addr` is the input address with every bit at or above the width cleared.
- R11: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and back-to-back requests are accepted. While `in_valid` is low, all result outputs hold. After reset, `out_valid` and `out_fault` are 0.
- R12: When `out_fault` is non-zero, `out_addr`, `out_root`, `out_shift`, `out_start_level`, `out_span` and `out_root_bits` are 0. Fault code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_va | input | 64 | Virtual address |
| in_exec | input | 1 | Request is an instruction fetch |
| lo_base | input | 64 | Lower-half translation base register |
| hi_base | input | 64 | Upper-half translation base register |
| lo_gran | input | 2 | Lower-half page-size code |
| hi_gran | input | 2 | Upper-half page-size code |
| lo_width | input | 7 | Lower-half address width in bits |
| hi_width | input | 7 | Upper-half address width in bits |
| lo_tbi | input | 1 | Lower-half top-byte skip enable |
| hi_tbi | input | 1 | Upper-half top-byte skip enable |
| lo_tbi_fetch | input | 1 | Lower-half top-byte skip enable for fetches |
| hi_tbi_fetch | input | 1 | Upper-half top-byte skip enable for fetches |
| out_valid | output | 1 | Result strobe |
| out_use_hi | output | 1 | Upper half was selected |
| out_addr | output | 64 | Address with out-of-range bits cleared |
| out_root | output | 64 | Aligned root table address |
| out_shift | output | 5 | Page shift |
| out_start_level | output | 2 | Starting level (level count − 1) |
| out_span | output | 6 | Address shift of the root index |
| out_root_bits | output | 6 | Root index width |
| out_fault | output | 2 | 0 none, 1 address size, 2 invalid configuration |

## Verification
A configuration fault and an address-size fault can be raised for the same request. For example, a reserved page-size code combined with an out-of-range width, or combined with a non-canonical address, triggers both checks at once. The bench drives such combined requests and expects the configuration code to win, with every result field zeroed. The bench also alternates lower-half and upper-half requests back to back. This checks that each cycle's half selection, canonical polarity and base register belong to that request alone and not to its neighbour.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

  localparam int WBITS = 7;

  typedef enum logic [1:0] {
    GRAN_4K   = 2'd0,
    GRAN_16K  = 2'd1,
    GRAN_64K  = 2'd2,
    GRAN_RSVD = 2'd3
  } gran_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SIZE = 2'd1,
    FLT_CFG  = 2'd2
  } fault_e;

  typedef struct packed {
    gran_e              gran;
    logic [WBITS-1:0]   width;
    logic               tbi;
    logic               tbi_fetch;
  } half_cfg_t;

  typedef struct packed {
    logic [4:0] shift;
    logic [1:0] start_level;
    logic [5:0] span;
    logic [5:0] root_bits;
  } geom_t;

  function automatic logic [4:0] gran_shift(gran_e g);
    case (g)
      GRAN_4K:  return 5'd12;
      GRAN_16K: return 5'd14;
      GRAN_64K: return 5'd16;
      default:  return 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/rtcc_half_sel.sv
module rtcc_half_sel
  import rtcc_pkg::*;
#(
  parameter int VA_W = 64
) (
  input  logic            sel,
  input  logic [VA_W-1:0] lo_base,
  input  logic [VA_W-1:0] hi_base,
  input  half_cfg_t       lo_cfg,
  input  half_cfg_t       hi_cfg,
  output logic            use_hi,
  output logic [VA_W-1:0] base,
  output half_cfg_t       cfg
);

  always_comb begin
    use_hi = sel;
    if (sel) begin
      base = hi_base;
      cfg  = hi_cfg;
    end else begin
      base = lo_base;
      cfg  = lo_cfg;
    end
  end

endmodule

// File: rtl/rtcc_geometry.sv
module rtcc_geometry
  import rtcc_pkg::*;
#(
  parameter int MIN_BITS   = 25,
  parameter int MAX_BITS   = 48,
  parameter int MAX_LEVELS = 4
) (
  input  gran_e            gran,
  input  logic [WBITS-1:0] width,
  output geom_t            geom,
  output fault_e           fault
);

  logic [4:0]       shift;
  logic [WBITS-1:0] levels;
  logic [5:0]       span_w;
  logic [5:0]       rbits_w;
  logic             width_bad;
  logic             levels_bad;

  always_comb begin
    shift = gran_shift(gran);
    case (gran)
      GRAN_4K:  levels = (width - WBITS'(1)) / WBITS'(12);
      GRAN_16K: levels = (width - WBITS'(1)) / WBITS'(14);
      GRAN_64K: levels = (width - WBITS'(1)) / WBITS'(16);
      default:  levels = '0;
    endcase
    span_w  = 6'(shift) + (6'(shift) - 6'd3) * (6'(levels) - 6'd1);
    rbits_w = 6'(width) - span_w;

    width_bad  = (width < WBITS'(MIN_BITS)) || (width > WBITS'(MAX_BITS));
    levels_bad = (levels == '0) || (levels > WBITS'(MAX_LEVELS));

    if (gran == GRAN_RSVD)  fault = FLT_CFG;
    else if (width_bad)     fault = FLT_SIZE;
    else if (levels_bad)    fault = FLT_CFG;
    else                    fault = FLT_NONE;

    geom.shift       = shift;
    geom.start_level = 2'(levels - WBITS'(1));
    geom.span        = span_w;
    geom.root_bits   = rbits_w;
  end

endmodule

// File: rtl/rtcc_canon.sv
module rtcc_canon
  import rtcc_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int TOP_BITS = 8
) (
  input  logic [VA_W-1:0]  va,
  input  logic [WBITS-1:0] width,
  input  logic             upper,
  input  logic             tbi,
  input  logic             tbi_fetch,
  input  logic             exec,
  output logic [VA_W-1:0]  in_range,
  output logic             ok
);

  localparam int TOP_LSB = VA_W - TOP_BITS;

  logic            skip_top;
  logic [VA_W-1:0] high_m;
  logic [VA_W-1:0] top_m;

  assign skip_top = tbi && (!exec || tbi_fetch);

  for (genvar i = 0; i < VA_W; i++) begin : g_bit
    assign high_m[i] = (i >= int'(width));
    if (i >= TOP_LSB) begin : g_top
      assign top_m[i] = skip_top;
    end else begin : g_low
      assign top_m[i] = 1'b0;
    end
  end

  always_comb begin
    if (upper) ok = &(va | top_m | ~high_m);
    else       ok = ~|((va & ~top_m) & high_m);
    in_range = va & ~high_m;
  end

endmodule

// File: rtl/rtcc_root_check.sv
module rtcc_root_check
  import rtcc_pkg::*;
#(
  parameter int VA_W        = 64,
  parameter int PA_BITS     = 48,
  parameter int SEL_BIT     = 54,
  parameter int MIN_VA_BITS = 25,
  parameter int MAX_VA_BITS = 48,
  parameter int MAX_LEVELS  = 4,
  parameter int TOP_BITS    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [VA_W-1:0]     in_va,
  input  logic                in_exec,
  input  logic [VA_W-1:0]     lo_base,
  input  logic [VA_W-1:0]     hi_base,
  input  logic [1:0]          lo_gran,
  input  logic [1:0]          hi_gran,
  input  logic [WBITS-1:0]    lo_width,
  input  logic [WBITS-1:0]    hi_width,
  input  logic                lo_tbi,
  input  logic                hi_tbi,
  input  logic                lo_tbi_fetch,
  input  logic                hi_tbi_fetch,
  output logic                out_valid,
  output logic                out_use_hi,
  output logic [VA_W-1:0]     out_addr,
  output logic [VA_W-1:0]     out_root,
  output logic [4:0]          out_shift,
  output logic [1:0]          out_start_level,
  output logic [5:0]          out_span,
  output logic [5:0]          out_root_bits,
  output logic [1:0]          out_fault
);

  localparam int ALIGN_PAD = 3;

  half_cfg_t       lo_cfg, hi_cfg, cfg;
  logic            use_hi;
  logic [VA_W-1:0] base;
  geom_t           geom;
  fault_e          geom_fault;
  logic [VA_W-1:0] in_range;
  logic            canon_ok;
  logic [VA_W-1:0] root_aligned;

  fault_e          fault_n;
  logic [VA_W-1:0] addr_n;
  logic [VA_W-1:0] root_n;
  geom_t           geom_n;

  logic            valid_q;
  logic            use_hi_q;
  logic [VA_W-1:0] addr_q;
  logic [VA_W-1:0] root_q;
  geom_t           geom_q;
  fault_e          fault_q;

  assign lo_cfg = '{gran: gran_e'(lo_gran), width: lo_width, tbi: lo_tbi, tbi_fetch: lo_tbi_fetch};
  assign hi_cfg = '{gran: gran_e'(hi_gran), width: hi_width, tbi: hi_tbi, tbi_fetch: hi_tbi_fetch};

  rtcc_half_sel #(.VA_W(VA_W)) u_sel (
    .sel     (in_va[SEL_BIT]),
    .lo_base (lo_base),
    .hi_base (hi_base),
    .lo_cfg  (lo_cfg),
    .hi_cfg  (hi_cfg),
    .use_hi  (use_hi),
    .base    (base),
    .cfg     (cfg)
  );

  rtcc_geometry #(
    .MIN_BITS   (MIN_VA_BITS),
    .MAX_BITS   (MAX_VA_BITS),
    .MAX_LEVELS (MAX_LEVELS)
  ) u_geom (
    .gran  (cfg.gran),
    .width (cfg.width),
    .geom  (geom),
    .fault (geom_fault)
  );

  rtcc_canon #(.VA_W(VA_W), .TOP_BITS(TOP_BITS)) u_canon (
    .va        (in_va),
    .width     (cfg.width),
    .upper     (use_hi),
    .tbi       (cfg.tbi),
    .tbi_fetch (cfg.tbi_fetch),
    .exec      (in_exec),
    .in_range  (in_range),
    .ok        (canon_ok)
  );

  // Root table address: keep bits PA_BITS-1..1, then clear the low
  // (root_bits + 3) bits so the table is aligned to its own size.
  for (genvar i = 0; i < VA_W; i++) begin : g_root
    if (i >= 1 && i < PA_BITS) begin : g_keep
      assign root_aligned[i] = base[i] & ~(i < int'(geom.root_bits) + ALIGN_PAD);
    end else begin : g_drop
      assign root_aligned[i] = 1'b0;
    end
  end

  // Next-state: configuration faults first, then the canonical check.
  always_comb begin
    fault_n = geom_fault;
    if (geom_fault == FLT_NONE && !canon_ok) fault_n = FLT_SIZE;
    if (fault_n == FLT_NONE) begin
      addr_n = in_range;
      root_n = root_aligned;
      geom_n = geom;
    end else begin
      addr_n = '0;
      root_n = '0;
      geom_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      use_hi_q <= 1'b0;
      addr_q   <= '0;
      root_q   <= '0;
      geom_q   <= '0;
      fault_q  <= FLT_NONE;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        use_hi_q <= use_hi;
        addr_q   <= addr_n;
        root_q   <= root_n;
        geom_q   <= geom_n;
        fault_q  <= fault_n;
      end
    end
  end

  assign out_valid       = valid_q;
  assign out_use_hi      = use_hi_q;
  assign out_addr        = addr_q;
  assign out_root        = root_q;
  assign out_shift       = geom_q.shift;
  assign out_start_level = geom_q.start_level;
  assign out_span        = geom_q.span;
  assign out_root_bits   = geom_q.root_bits;
  assign out_fault       = fault_q;

endmodule

// File: rtl/rtcc_checker.sv
module rtcc_checker #(
  parameter int VA_W    = 64,
  parameter int PA_BITS = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            sel_in,
  input logic            out_valid,
  input logic            out_use_hi,
  input logic [VA_W-1:0] out_addr,
  input logic [VA_W-1:0] out_root,
  input logic [4:0]      out_shift,
  input logic [1:0]      out_start_level,
  input logic [5:0]      out_span,
  input logic [5:0]      out_root_bits,
  input logic [1:0]      out_fault
);

  logic [VA_W-1:0] align_m;
  logic [VA_W-1:0] fit_m;
  logic [5:0]      span_calc;
  logic            good;

  always_comb begin
    for (int i = 0; i < VA_W; i++) begin
      align_m[i] = (i < int'(out_root_bits) + 3);
      fit_m[i]   = (i >= int'(out_span) + int'(out_root_bits));
    end
    span_calc = 6'(out_shift) + (6'(out_shift) - 6'd3) * 6'(out_start_level);
    good      = out_valid && (out_fault == 2'd0);
  end

  p_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_use_hi == $past(sel_in)));

  p_shift_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    good |-> (out_shift == 5'd12 || out_shift == 5'd14 || out_shift == 5'd16));

  p_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
    good |-> (out_span == span_calc));

  p_root_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    good |-> (((out_root & align_m) == '0) && (out_root[VA_W-1:PA_BITS] == '0)));

  p_addr_fit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    good |-> ((out_addr & fit_m) == '0));

  p_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_addr) && $stable(out_root) && $stable(out_fault)));

  p_fault_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault != 2'd0) |-> (out_addr == '0 && out_root == '0 && out_span == '0
                                          && out_root_bits == '0 && out_shift == '0));

  p_fault_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault != 2'd3);

endmodule

bind rtcc_root_check rtcc_checker #(.VA_W(VA_W), .PA_BITS(PA_BITS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .sel_in          (in_va[SEL_BIT]),
  .out_valid       (out_valid),
  .out_use_hi      (out_use_hi),
  .out_addr        (out_addr),
  .out_root        (out_root),
  .out_shift       (out_shift),
  .out_start_level (out_start_level),
  .out_span        (out_span),
  .out_root_bits   (out_root_bits),
  .out_fault       (out_fault)
);

// File: tb/sim_rtcc_root_check.sv
module sim_rtcc_root_check;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] va;
  logic        exec;
  logic [63:0] lo_base, hi_base;
  logic [1:0]  lo_gran, hi_gran;
  logic [6:0]  lo_w, hi_w;
  logic        lo_tbi, hi_tbi, lo_tf, hi_tf;

  logic        out_valid, out_use_hi;
  logic [63:0] out_addr, out_root;
  logic [4:0]  out_shift;
  logic [1:0]  out_start_level;
  logic [5:0]  out_span, out_root_bits;
  logic [1:0]  out_fault;

  int checks = 0;
  int errors = 0;

  rtcc_root_check u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_va(va), .in_exec(exec),
    .lo_base(lo_base), .hi_base(hi_base), .lo_gran(lo_gran), .hi_gran(hi_gran),
    .lo_width(lo_w), .hi_width(hi_w), .lo_tbi(lo_tbi), .hi_tbi(hi_tbi),
    .lo_tbi_fetch(lo_tf), .hi_tbi_fetch(hi_tf),
    .out_valid(out_valid), .out_use_hi(out_use_hi), .out_addr(out_addr),
    .out_root(out_root), .out_shift(out_shift), .out_start_level(out_start_level),
    .out_span(out_span), .out_root_bits(out_root_bits), .out_fault(out_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference from the requirements
  task automatic model(output logic [1:0] f, output logic h, output logic [63:0] a,
                       output logic [63:0] r, output logic [4:0] s, output logic [1:0] sl,
                       output logic [5:0] sp, output logic [5:0] rb);
    int w, sh, lv, spn, rbi;
    logic [1:0]  g;
    logic        tb, okv;
    logic [63:0] base, hm, m;
    h    = va[54];
    g    = h ? hi_gran : lo_gran;
    w    = h ? int'(hi_w) : int'(lo_w);
    base = h ? hi_base : lo_base;
    tb   = h ? (hi_tbi && (!exec || hi_tf)) : (lo_tbi && (!exec || lo_tf));
    sh   = (g == 2'd0) ? 12 : (g == 2'd1) ? 14 : (g == 2'd2) ? 16 : 0;
    f = 2'd0; spn = 0; rbi = 0; lv = 0; hm = '0;
    if (g == 2'd3) f = 2'd2;
    else if (w < 25 || w > 48) f = 2'd1;
    else begin
      lv = (w - 1) / sh;
      if (lv < 1 || lv > 4) f = 2'd2;
      else begin
        spn = sh + (sh - 3) * (lv - 1);
        rbi = w - spn;
        hm  = ~((64'd1 << w) - 64'd1);
        if (h) begin
          m   = va | (tb ? 64'hFF00_0000_0000_0000 : 64'd0);
          okv = ((m & hm) == hm);
        end else begin
          m   = va & (tb ? 64'h00FF_FFFF_FFFF_FFFF : '1);
          okv = ((m & hm) == 64'd0);
        end
        if (!okv) f = 2'd1;
      end
    end
    if (f != 2'd0) begin
      a = '0; r = '0; s = '0; sl = '0; sp = '0; rb = '0;
    end else begin
      a  = va & ~hm;
      r  = (base & 64'h0000_FFFF_FFFF_FFFE) & ~((64'd1 << (rbi + 3)) - 64'd1);
      s  = 5'(sh);
      sl = 2'(lv - 1);
      sp = 6'(spn);
      rb = 6'(rbi);
    end
  endtask

  task automatic cmp(string tag, logic [1:0] f, logic h, logic [63:0] a, logic [63:0] r,
                     logic [4:0] s, logic [1:0] sl, logic [5:0] sp, logic [5:0] rb);
    chk({tag, " valid"}, 64'(out_valid), 64'd1);
    chk({tag, " fault"}, 64'(out_fault), 64'(f));
    chk({tag, " half"},  64'(out_use_hi), 64'(h));
    chk({tag, " addr"},  out_addr, a);
    chk({tag, " root"},  out_root, r);
    chk({tag, " shift"}, 64'(out_shift), 64'(s));
    chk({tag, " level"}, 64'(out_start_level), 64'(sl));
    chk({tag, " span"},  64'(out_span), 64'(sp));
    chk({tag, " rbits"}, 64'(out_root_bits), 64'(rb));
  endtask

  task automatic run_one(string tag);
    logic [1:0] f; logic h; logic [63:0] a, r; logic [4:0] s; logic [1:0] sl;
    logic [5:0] sp, rb;
    @(negedge clk);
    in_valid = 1'b1;
    model(f, h, a, r, s, sl, sp, rb);
    @(negedge clk);
    in_valid = 1'b0;
    cmp(tag, f, h, a, r, s, sl, sp, rb);
  endtask

  task automatic cfg_default();
    exec = 1'b0;
    lo_gran = 2'd0; hi_gran = 2'd0; lo_w = 7'd48; hi_w = 7'd48;
    lo_tbi = 1'b0; hi_tbi = 1'b0; lo_tf = 1'b0; hi_tf = 1'b0;
    lo_base = 64'hFFFF_8000_1234_5FFF;
    hi_base = 64'h0001_4567_89AB_CDEF;
  endtask

  task automatic t_reset();
    chk("R11 reset valid", 64'(out_valid), 64'd0);
    chk("R11 reset fault", 64'(out_fault), 64'd0);
  endtask

  task automatic t_lower_geom();
    cfg_default();
    va = 64'h0000_1234_5678_9ABC;
    run_one("R4 R5 R6 R10 lower 4K");
    chk("R6 literal root", out_root, 64'h0000_8000_1220_0000);
    chk("R5 literal span", 64'(out_span), 64'd30);
    chk("R5 literal rbits", 64'(out_root_bits), 64'd18);
    chk("R4 literal level", 64'(out_start_level), 64'd2);
    lo_gran = 2'd1; lo_w = 7'd39; va = 64'h0000_0040_0000_0123;
    run_one("R2 R5 lower 16K");
    chk("R5 literal span 16K", 64'(out_span), 64'd25);
    lo_gran = 2'd2; lo_w = 7'd42; va = 64'h0000_0200_0000_0FFF;
    run_one("R2 R5 lower 64K");
    chk("R2 literal shift 64K", 64'(out_shift), 64'd16);
  endtask

  task automatic t_upper();
    cfg_default();
    va = 64'hFFFF_FF80_0000_1000;
    run_one("R1 R8 upper basic");
    chk("R1 literal half", 64'(out_use_hi), 64'd1);
    chk("R10 literal addr", out_addr, 64'h0000_FF80_0000_1000);
    hi_gran = 2'd1; hi_w = 7'd30;
    va = 64'hFFFF_FFFF_C000_0040;
    run_one("R1 R8 upper 16K w30");
  endtask

  task automatic t_bad_gran();
    cfg_default();
    lo_gran = 2'd3; va = 64'h0000_0000_0000_1000;
    run_one("R2 reserved granule");
    chk("R2 literal code", 64'(out_fault), 64'd2);
    lo_w = 7'd60; va = 64'h8F00_0000_0000_1000;
    run_one("R3 granule beats width and canon");
    chk("R12 literal zero root", out_root, 64'd0);
  endtask

  task automatic t_width_edges();
    cfg_default();
    va = 64'h0000_0000_0000_2000;
    lo_w = 7'd24; run_one("R3 width 24");
    chk("R3 literal size code", 64'(out_fault), 64'd1);
    lo_w = 7'd49; run_one("R3 width 49");
    lo_w = 7'd25; run_one("R3 width 25 accepted");
    lo_gran = 2'd2; run_one("R4 64K width 25");
    lo_w = 7'd48; lo_gran = 2'd1; run_one("R4 16K width 48");
  endtask

  task automatic t_lower_canon();
    cfg_default();
    lo_w = 7'd40;
    va = 64'h0000_0100_0000_0000; run_one("R7 bit at width set");
    chk("R7 literal fault", 64'(out_fault), 64'd1);
    va = 64'h0000_00FF_FFFF_FFFF; run_one("R7 top in-range bit");
    va = 64'h5A00_0012_3400_0000; run_one("R7 tag without skip");
    lo_tbi = 1'b1; run_one("R7 tag with skip");
    chk("R7 literal ok", 64'(out_fault), 64'd0);
    va = 64'h5A80_0012_3400_0000; run_one("R7 bit 55 with skip");
  endtask

  task automatic t_upper_canon();
    cfg_default();
    va = 64'hFFFE_FF80_0000_1000; run_one("R8 zero bit in high part");
    chk("R8 literal fault", 64'(out_fault), 64'd1);
    va = 64'h00FF_FF80_0000_1000; run_one("R8 tag without skip");
    hi_tbi = 1'b1; run_one("R8 tag with skip");
    chk("R8 literal ok", 64'(out_fault), 64'd0);
  endtask

  task automatic t_fetch_skip();
    cfg_default();
    lo_tbi = 1'b1; va = 64'hA500_0000_0000_4000;
    exec = 1'b1; run_one("R9 fetch without fetch bit");
    chk("R9 literal fault", 64'(out_fault), 64'd1);
    lo_tf = 1'b1; run_one("R9 fetch with fetch bit");
    chk("R9 literal ok", 64'(out_fault), 64'd0);
    exec = 1'b0; lo_tf = 1'b0; run_one("R9 data access skip");
    hi_tbi = 1'b1; exec = 1'b1; va = 64'h12FF_FF80_0000_0000;
    run_one("R9 upper fetch without fetch bit");
  endtask

  task automatic t_stream();
    logic [1:0] f; logic h; logic [63:0] a, r; logic [4:0] s; logic [1:0] sl;
    logic [5:0] sp, rb;
    logic [63:0] vas [4];
    cfg_default();
    hi_gran = 2'd2; hi_w = 7'd36;
    vas[0] = 64'h0000_0ABC_0000_0010;
    vas[1] = 64'hFFFF_FFF0_0000_0020;
    vas[2] = 64'h0001_0000_0000_0000;
    vas[3] = 64'hFFFF_FFFC_1234_5678;
    f = '0; h = 1'b0; a = '0; r = '0; s = '0; sl = '0; sp = '0; rb = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i > 0) cmp($sformatf("R11 R1 stream %0d", i - 1), f, h, a, r, s, sl, sp, rb);
      va = vas[i];
      in_valid = 1'b1;
      model(f, h, a, r, s, sl, sp, rb);
    end
    @(negedge clk);
    in_valid = 1'b0;
    va = 64'h0000_0000_0000_0000;
    cmp("R11 R1 stream 3", f, h, a, r, s, sl, sp, rb);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk("R11 idle valid low", 64'(out_valid), 64'd0);
      chk("R11 idle root held", out_root, r);
      chk("R11 idle addr held", out_addr, a);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    va = '0;
    cfg_default();
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_lower_geom();
    t_upper();
    t_bad_gran();
    t_width_edges();
    t_lower_canon();
    t_upper_canon();
    t_fetch_skip();
    t_stream();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule